// File: doc/BRIEF.md
# Two-Wire DAC Code and Output Port Slave

This block is a serial-bus slave that owns one 8-bit setting register. The upper five bits of the register form a DAC code, and the lower three bits drive three general-purpose digital output pins. A fast system clock oversamples the SCL and SDA lines through two-flop synchronizers. In that clock domain the block finds START and STOP conditions and the SCL edges. SDA is driven as an open-drain enable: when `sda_oe_o` is 1 the line is pulled low.

A host writes the register by sending the 7-bit address with R/W clear, then a fixed command byte, then the data byte. A host reads the register by sending the address with R/W set. The slave answers with a fixed prefix byte and then the register contents. The host acknowledges both of these bytes.

The stored DAC code has a falling sense: a larger code selects a lower analog level. For this reason the block presents both the raw code and its complement. The complement rises with the analog level.

Top module: `twi_dac_port_slave`

## Requirements
- R1: The slave address is 7'b0101100. A first byte of 58h (write) or 59h (read) after START is acknowledged: `sda_oe_o` is 1 during the 9th SCL pulse.
- R2: Any other first byte gets no ACK. The slave then leaves SDA released and ignores the bus until the next START, and the register is unchanged.
- R3: A write of START, 58h, AAh, D, STOP stores D in the register, and each of the three bytes is acknowledged. Bytes are sent MSB first.
- R4: In a write, a second byte other than AAh is not acknowledged, and the data byte that follows is discarded.
- R5: A read of START, 59h, then two host-acknowledged bytes returns 00h followed by the register contents, each MSB first.
- R6: After reset the register is 00h, so `dac_code_o`=0, `dac_level_o`=31, `port_o`=0 and `sda_oe_o`=0.
- R7: `dac_code_o` equals register bits [7:3], `dac_level_o` equals their bitwise complement, and `port_o[i]` equals register bit i for i = 0..2.
- R8: The register changes only once the 8th bit of an accepted data byte has been sampled. A STOP or START earlier in that byte leaves it unchanged, and outputs hold in every cycle without a write.
- R9: A START in any state, including a repeated START in mid-byte or mid-transaction, restarts address reception. The slave releases SDA in the cycle after any START or STOP.
- R10: The slave asserts its SDA drive only while the synchronized SCL is low, so each bit it sends is stable at the next rising SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| dac_code_o | output | 5 | Raw DAC code, register bits [7:3] |
| dac_level_o | output | 5 | Complemented code, rising with output level |
| port_o | output | 3 | Digital output pins from register bits [2:0] |

## Verification
The bound checker watches four things on every cycle:
- that SDA drive only rises while synchronized SCL is low;
- that a START or STOP releases SDA on the next cycle;
- that the write strobe is a single-cycle pulse;
- that the DAC and port outputs hold whenever no write strobe is present.

Several behaviours can only be shown by the bench's transactions against its own register model:
- address and command filtering, and the ACK pattern on each byte;
- the 00h prefix and register value on read;
- discarding a byte cut short by STOP or a repeated START;
- recovery after an address mismatch.

// File: rtl/twi_dac_pkg.sv
package twi_dac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [2:0] pipe;
    // idle bus is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '1;
      else         pipe <= {pipe[1:0], line_i[g]};
    end
    assign lvl_o[g]  = pipe[1];
    assign prev_o[g] = pipe[2];
  end
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_dac_pkg::*;
#(
  parameter int unsigned           BYTE_W    = 8,
  parameter logic [BYTE_W-2:0]     ADDR      = 7'b0101100,
  parameter logic [BYTE_W-1:0]     CMD_WR    = 8'hAA,
  parameter logic [BYTE_W-1:0]     RD_PREFIX = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int unsigned    CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  twi_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [1:0]        byte_idx;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] tx_sh;
  logic              is_read, ack_pend, mack, oe_q;
  logic [BYTE_W-1:0] rx_byte;
  logic              addr_hit;

  assign rx_byte  = {shreg, sda_lvl_i};
  assign addr_hit = (rx_byte[BYTE_W-1:1] == ADDR);
  assign sda_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      byte_idx  <= '0;
      shreg     <= '0;
      tx_sh     <= '0;
      is_read   <= 1'b0;
      ack_pend  <= 1'b0;
      mack      <= 1'b0;
      oe_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state    <= ST_RX;
        bit_cnt  <= '0;
        byte_idx <= '0;
        ack_pend <= 1'b0;
        oe_q     <= 1'b0;
      end else if (stop_i) begin
        state <= ST_IDLE;
        oe_q  <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise_i && bit_cnt < FULL) begin
              shreg   <= rx_byte[BYTE_W-2:0];
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) begin
                unique case (byte_idx)
                  2'd0: begin
                    ack_pend <= addr_hit;
                    is_read  <= rx_byte[0];
                  end
                  2'd1: ack_pend <= (rx_byte == CMD_WR);
                  default: begin
                    ack_pend  <= 1'b1;
                    wr_en_o   <= 1'b1;
                    wr_data_o <= rx_byte;
                  end
                endcase
              end
            end else if (scl_fall_i && bit_cnt == FULL) begin
              if (ack_pend) begin
                state <= ST_RX_ACK;
                oe_q  <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              bit_cnt <= '0;
              if (byte_idx == 2'd0 && is_read) begin
                state    <= ST_TX;
                tx_sh    <= RD_PREFIX;
                oe_q     <= ~RD_PREFIX[BYTE_W-1];
                byte_idx <= 2'd1;
              end else if (byte_idx == 2'd2) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
              end else begin
                state    <= ST_RX;
                oe_q     <= 1'b0;
                byte_idx <= byte_idx + 1'b1;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i) begin
              if (bit_cnt == FULL) begin
                state <= ST_TX_ACK;
                oe_q  <= 1'b0;
              end else begin
                tx_sh <= tx_sh << 1;
                oe_q  <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              mack <= ~sda_lvl_i;
            end else if (scl_fall_i) begin
              if (mack && byte_idx == 2'd1) begin
                state    <= ST_TX;
                tx_sh    <= rd_data_i;
                oe_q     <= ~rd_data_i[BYTE_W-1];
                byte_idx <= 2'd2;
                bit_cnt  <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dac_port_reg.sv
module dac_port_reg #(
  parameter int unsigned DAC_W  = 5,
  parameter int unsigned PORT_W = 3,
  localparam int unsigned DATA_W = DAC_W + PORT_W,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] q_o,
  output logic [DAC_W-1:0]  dac_code_o,
  output logic [DAC_W-1:0]  dac_level_o,
  output logic [PORT_W-1:0] port_o
);
  logic [DATA_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= RESET_VAL;
    else if (wr_en_i) q <= wr_data_i;
  end

  assign q_o         = q;
  assign dac_code_o  = q[DATA_W-1:PORT_W];
  // stored code falls with level; complement rises with it
  assign dac_level_o = ~q[DATA_W-1:PORT_W];

  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    assign port_o[p] = q[p];
  end
endmodule

// File: rtl/twi_dac_port_slave.sv
module twi_dac_port_slave #(
  parameter int unsigned DAC_W     = 5,
  parameter int unsigned PORT_W    = 3,
  parameter logic [DAC_W+PORT_W-2:0] SLAVE_ADDR = 7'b0101100,
  parameter logic [DAC_W+PORT_W-1:0] CMD_WR     = 8'hAA,
  parameter logic [DAC_W+PORT_W-1:0] RD_PREFIX  = 8'h00,
  parameter logic [DAC_W+PORT_W-1:0] RESET_VAL  = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [DAC_W-1:0]  dac_code_o,
  output logic [DAC_W-1:0]  dac_level_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int unsigned DATA_W = DAC_W + PORT_W;

  logic [1:0] lvl, prev;
  logic scl_lvl, scl_prv, sda_lvl, sda_prv;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [DATA_W-1:0] wr_data, reg_q;

  twi_line_sync #(.N(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  assign scl_lvl   = lvl[0];
  assign scl_prv   = prev[0];
  assign sda_lvl   = lvl[1];
  assign sda_prv   = prev[1];
  assign scl_rise  = scl_lvl & ~scl_prv;
  assign scl_fall  = ~scl_lvl & scl_prv;
  assign start_det = scl_lvl & scl_prv & sda_prv & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prv & ~sda_prv & sda_lvl;

  twi_slave_fsm #(
    .BYTE_W    (DATA_W),
    .ADDR      (SLAVE_ADDR),
    .CMD_WR    (CMD_WR),
    .RD_PREFIX (RD_PREFIX)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_lvl_i  (sda_lvl),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rd_data_i  (reg_q),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data)
  );

  dac_port_reg #(
    .DAC_W     (DAC_W),
    .PORT_W    (PORT_W),
    .RESET_VAL (RESET_VAL)
  ) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .q_o         (reg_q),
    .dac_code_o  (dac_code_o),
    .dac_level_o (dac_level_o),
    .port_o      (port_o)
  );
endmodule

// File: rtl/twi_dac_checker.sv
module twi_dac_checker #(
  parameter int unsigned DAC_W  = 5,
  parameter int unsigned PORT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_lvl_i,
  input logic              sda_oe_i,
  input logic              start_i,
  input logic              stop_i,
  input logic              wr_en_i,
  input logic [DAC_W-1:0]  dac_code_i,
  input logic [PORT_W-1:0] port_i
);
  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_lvl_i);

  p_start_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  p_stop_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  p_wr_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i);

  p_hold_no_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable({dac_code_i, port_i}));
endmodule

bind twi_dac_port_slave twi_dac_checker #(.DAC_W(DAC_W), .PORT_W(PORT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_lvl_i  (scl_lvl),
  .sda_oe_i   (sda_oe_o),
  .start_i    (start_det),
  .stop_i     (stop_det),
  .wr_en_i    (wr_en),
  .dac_code_i (dac_code_o),
  .port_i     (port_o)
);

// File: tb/tb_twi_dac_port_slave.sv
module tb_twi_dac_port_slave;
  localparam int Q = 10; // clocks per quarter SCL period

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe_o;
  logic sda_bus;
  logic [4:0] dac_code_o, dac_level_o;
  logic [2:0] port_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] exp_reg = 8'h00;

  always #5 clk_i = ~clk_i;
  assign sda_bus = sda_m & ~sda_oe_o;

  twi_dac_port_slave dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe_o),
    .dac_code_o  (dac_code_o),
    .dac_level_o (dac_level_o),
    .port_o      (port_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    chk({req, " dac_code"},  {27'd0, dac_code_o},  {27'd0, exp_reg[7:3]});
    chk({req, " dac_level"}, {27'd0, dac_level_o}, {27'd0, ~exp_reg[7:3]});
    chk({req, " port"},      {29'd0, port_o},      {29'd0, exp_reg[2:0]});
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_bus;  tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    read_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) read_bit(d[i]);
    send_bit(1'b0); // host ACK
  endtask

  function automatic logic [7:0] pick_bad_addr(input logic [7:0] r);
    return (r[7:1] == 7'h2C) ? {~r[7], r[6:0]} : r;
  endfunction

  task automatic wr_txn(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d);
    logic a0, a1, a2, e0, e1;
    bus_start;
    wr_byte(a, a0);
    wr_byte(c, a1);
    wr_byte(d, a2);
    bus_stop;
    tick(4);
    e0 = (a == 8'h58);
    e1 = e0 && (c == 8'hAA);
    chk("R1/R2 addr ack", {31'd0, a0}, {31'd0, e0});
    chk("R4 cmd ack", {31'd0, a1}, {31'd0, e1});
    chk("R3 data ack", {31'd0, a2}, {31'd0, e1});
    if (e1) exp_reg = d;
    chk_outputs("R3/R7");
    chk("R2 sda released", {31'd0, sda_oe_o}, 32'd0);
  endtask

  task automatic rd_txn(input logic [7:0] a);
    logic a0, e0;
    logic [7:0] b0, b1;
    bus_start;
    wr_byte(a, a0);
    rd_byte(b0);
    rd_byte(b1);
    bus_stop;
    tick(4);
    e0 = (a == 8'h59);
    chk("R1/R2 read addr ack", {31'd0, a0}, {31'd0, e0});
    // R10: bits sampled mid-high must match
    chk("R5 prefix byte", {24'd0, b0}, e0 ? 32'h00 : 32'hFF);
    chk("R5 data byte", {24'd0, b1}, e0 ? {24'd0, exp_reg} : 32'hFF);
  endtask

  initial begin
    logic ak;
    logic [7:0] r;
    void'($urandom(32'h5EED1234));
    tick(3);
    rst_ni = 1'b1;
    tick(3);
    // R6 reset state
    chk_outputs("R6");
    chk("R6 oe", {31'd0, sda_oe_o}, 32'd0);
    rd_txn(8'h59);

    // R3 R7 extreme code
    wr_txn(8'h58, 8'hAA, 8'hF8);
    wr_txn(8'h58, 8'hAA, 8'h07);
    rd_txn(8'h59);
    // R2 wrong address
    wr_txn(8'h5A, 8'hAA, 8'h33);
    rd_txn(8'hB9);
    // R4 wrong command
    wr_txn(8'h58, 8'hAB, 8'h44);
    rd_txn(8'h59);

    // R8 STOP in mid data byte
    bus_start;
    wr_byte(8'h58, ak);
    wr_byte(8'hAA, ak);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bus_stop;
    tick(4);
    chk_outputs("R8 stop abort");
    rd_txn(8'h59);

    // R9 repeated START in mid data byte, then full write
    bus_start;
    wr_byte(8'h58, ak);
    wr_byte(8'hAA, ak);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    tick(2);
    chk_outputs("R9 mid-byte hold");
    wr_txn(8'h58, 8'hAA, 8'h5C);

    // R9 repeated START after address, switch to read
    begin
      logic [7:0] b0, b1;
      bus_start;
      wr_byte(8'h58, ak);
      chk("R9 first addr ack", {31'd0, ak}, 32'd1);
      bus_start;
      wr_byte(8'h59, ak);
      rd_byte(b0);
      rd_byte(b1);
      bus_stop;
      tick(4);
      chk("R9 restart ack", {31'd0, ak}, 32'd1);
      chk("R9 restart prefix", {24'd0, b0}, 32'h00);
      chk("R9 restart data", {24'd0, b1}, {24'd0, exp_reg});
    end

    // constrained random mix
    for (int n = 0; n < 40; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      r = 8'($urandom);
      if (sel < 5)       wr_txn(8'h58, 8'hAA, r);
      else if (sel == 5) wr_txn(8'h58, 8'($urandom) | 8'h01, r);
      else if (sel == 6) wr_txn(pick_bad_addr(8'($urandom)), 8'hAA, r);
      else if (sel == 7) rd_txn(pick_bad_addr(8'($urandom)));
      else               rd_txn(8'h59);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule